// File: doc/BRIEF.md
# Self-Timed Program and Erase Engine with Status Readback

This block carries out word programming and two kinds of bulk erase on a 16-bit-wide word array. Each operation runs on its own internal timer. While one runs, the block replaces part of every read with live progress status. A host starts an operation with a one-cycle request and gives no further timing. It learns that the operation has finished by watching the busy flag, or by reading any word and looking at the status bits. The array depth, the size of the protected boot region and both operation lengths are parameters given in clock cycles. Simulation can therefore use short runs in place of microseconds and milliseconds.

Programming can only clear bits: the stored word becomes the old word ANDed with the new data. Erase writes all-ones words. A chip erase covers the whole array unless the lockout flag protects the low boot region. A main erase never touches that region. While an operation runs, two bit positions in each byte lane carry status. The polling bits (7 and 15) read inverted during a program and read zero during an erase. The toggle bits (6 and 14) invert from one read to the next. All other bits show the array word at the read address.

Top module: `flash_status_engine`

## Requirements
- R1: `bus_oe` is 1 only while `ce_n` and `oe_n` are both 0. Whenever `bus_oe` is 0, `rd_data` is 0.
- R2: While idle, a read returns the array word at `rd_addr` unchanged.
- R3: An accepted program request stores (old word AND `prog_data`) at `prog_addr`.
- R4: An accepted program makes `busy` rise after the accepting clock edge and stay high for exactly `PROG_CYCLES` cycles.
- R5: A program request is refused when `lock_boot` is 1 and `prog_addr` < `BOOT_WORDS`. A refused request leaves `busy` at 0 and the word unchanged. Addresses at or above `BOOT_WORDS` are still programmed.
- R6: A chip erase keeps `busy` high for exactly `ERASE_CYCLES` cycles. It leaves every word equal to 16'hFFFF when `lock_boot` was 0 at acceptance. When `lock_boot` was 1, it leaves words below `BOOT_WORDS` unchanged.
- R7: A main erase sets every word at or above `BOOT_WORDS` to 16'hFFFF and never changes words below `BOOT_WORDS`, whatever the value of `lock_boot`.
- R8: During a program, read bits 7 and 15 are the inverse of bits 7 and 15 of the word just stored.
- R9: During an erase, read bits 7 and 15 are 0.
- R10: While busy, bits 6 and 14 are equal and stay constant through one read. Successive reads see them inverted. Once the operation has finished, they show array data.
- R11: While busy, read bits other than 6, 7, 14 and 15 show the array word at `rd_addr`.
- R12: Requests that arrive while busy are ignored. When requests arrive together while idle, chip erase wins over main erase, and main erase wins over program.
- R13: After reset, `busy`, `bus_oe` and `rd_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_req | input | 1 | One-cycle program request |
| prog_addr | input | AW | Word address to program |
| prog_data | input | 16 | Data to program (can only clear bits) |
| chip_erase_req | input | 1 | One-cycle chip erase request |
| main_erase_req | input | 1 | One-cycle erase request for the region above the boot block |
| lock_boot | input | 1 | Boot region protection flag |
| ce_n | input | 1 | Active-low chip select for reads |
| oe_n | input | 1 | Active-low output enable for reads |
| rd_addr | input | AW | Read word address |
| busy | output | 1 | An operation is running |
| rd_data | output | 16 | Read data, with status bits substituted while busy |
| bus_oe | output | 1 | Drive enable for the external tri-state data bus |

## Verification
The assertions assume that a read is a stretch of consecutive cycles with `ce_n` and `oe_n` both low, and that `rd_addr` does not change within a stretch. They also assume that requests last one cycle. The toggle-hold property relies on this. The stimulus always opens a read on a falling clock edge, holds the address across one rising edge, and closes it on the next falling edge. Every request is pulsed for exactly one cycle. The lockout flag changes only while the engine is idle, so the refusal check on a boot-region program always sees a stable flag.

// File: rtl/fes_pkg.sv
package fes_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2
    } op_e;

    // Context of the running operation
    typedef struct packed {
        op_e               kind;
        logic              skip_boot;
        logic [WORD_W-1:0] stored;
    } op_ctx_t;

    // Merge live status into an array word while an operation runs
    function automatic logic [WORD_W-1:0] status_word(
        input logic [WORD_W-1:0] arr,
        input logic [WORD_W-1:0] stored,
        input op_e               kind,
        input logic              tgl
    );
        logic [WORD_W-1:0] w;
        w     = arr;
        w[6]  = tgl;
        w[14] = tgl;
        w[7]  = (kind == OP_PROG) ? ~stored[7]  : 1'b0;
        w[15] = (kind == OP_PROG) ? ~stored[15] : 1'b0;
        return w;
    endfunction

endpackage

// File: rtl/fes_array.sv
module fes_array #(
    parameter int AW = 10
) (
    input  logic                       clk,
    input  logic                       we,
    input  logic [AW-1:0]              waddr,
    input  logic [fes_pkg::WORD_W-1:0] wdata,
    input  logic [AW-1:0]              raddr,
    output logic [fes_pkg::WORD_W-1:0] rdata,
    input  logic [AW-1:0]              paddr,
    output logic [fes_pkg::WORD_W-1:0] pdata
);
    localparam int DEPTH = 1 << AW;

    logic [fes_pkg::WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
    assign pdata = mem[paddr];
endmodule

// File: rtl/fes_timer.sv
module fes_timer #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] len_m1,
    output logic          running,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            cnt_q   <= '0;
        end else if (start) begin
            running <= 1'b1;
            cnt_q   <= len_m1;
        end else if (running) begin
            if (cnt_q == '0) running <= 1'b0;
            else             cnt_q   <= cnt_q - 1'b1;
        end
    end

    assign last = running && (cnt_q == '0);
endmodule

// File: rtl/fes_read_path.sv
module fes_read_path
    import fes_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              busy,
    input  op_ctx_t           ctx,
    input  logic [WORD_W-1:0] arr_word,
    output logic              bus_oe,
    output logic [WORD_W-1:0] rd_data
);
    logic rd_active;
    logic rd_prev_q;
    logic tgl_q;

    assign rd_active = !ce_n && !oe_n;

    // Toggle state advances when a read stretch closes
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_prev_q <= 1'b0;
            tgl_q     <= 1'b0;
        end else begin
            rd_prev_q <= rd_active;
            if (busy && rd_prev_q && !rd_active) tgl_q <= ~tgl_q;
        end
    end

    always_comb begin
        bus_oe  = rd_active;
        rd_data = '0;
        if (rd_active) begin
            rd_data = busy ? status_word(arr_word, ctx.stored, ctx.kind, tgl_q)
                           : arr_word;
        end
    end
endmodule

// File: rtl/flash_status_engine.sv
module flash_status_engine
    import fes_pkg::*;
#(
    parameter int AW           = 10,
    parameter int BOOT_WORDS   = 128,
    parameter int PROG_CYCLES  = 20,
    parameter int ERASE_CYCLES = 1100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_req,
    input  logic [AW-1:0]     prog_addr,
    input  logic [WORD_W-1:0] prog_data,
    input  logic              chip_erase_req,
    input  logic              main_erase_req,
    input  logic              lock_boot,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [AW-1:0]     rd_addr,
    output logic              busy,
    output logic [WORD_W-1:0] rd_data,
    output logic              bus_oe
);
    localparam int            MAXC      = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
    localparam int            CW        = $clog2(MAXC + 1);
    localparam logic [CW-1:0] PROG_LEN  = CW'(PROG_CYCLES - 1);
    localparam logic [CW-1:0] ERASE_LEN = CW'(ERASE_CYCLES - 1);
    localparam logic [AW-1:0] BOOT_LIM  = AW'(BOOT_WORDS);

    op_ctx_t           ctx_q;
    op_e               op_kind;
    logic [AW:0]       sweep_q;
    logic              idle, boot_hit;
    logic              start_chip, start_main, start_prog, start_any;
    logic              tmr_running, tmr_last;
    logic              arr_we;
    logic [AW-1:0]     arr_waddr;
    logic [WORD_W-1:0] arr_wdata, arr_rdata, arr_pdata, merged;
    logic              erase_we;

    assign op_kind  = ctx_q.kind;
    assign idle     = (ctx_q.kind == OP_NONE);
    assign boot_hit = (prog_addr < BOOT_LIM);

    // Priority: chip erase, then main erase, then program
    assign start_chip = idle && chip_erase_req;
    assign start_main = idle && !chip_erase_req && main_erase_req;
    assign start_prog = idle && !chip_erase_req && !main_erase_req && prog_req
                        && !(lock_boot && boot_hit);
    assign start_any  = start_chip || start_main || start_prog;

    assign merged   = arr_pdata & prog_data;
    assign erase_we = (ctx_q.kind == OP_ERASE) && !sweep_q[AW]
                      && !(ctx_q.skip_boot && (sweep_q[AW-1:0] < BOOT_LIM));

    always_comb begin
        arr_we    = 1'b0;
        arr_waddr = sweep_q[AW-1:0];
        arr_wdata = '1;
        if (start_prog) begin
            arr_we    = 1'b1;
            arr_waddr = prog_addr;
            arr_wdata = merged;
        end else if (erase_we) begin
            arr_we    = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q   <= '{kind: OP_NONE, skip_boot: 1'b0, stored: '0};
            sweep_q <= '0;
        end else if (start_prog) begin
            ctx_q.kind   <= OP_PROG;
            ctx_q.stored <= merged;
        end else if (start_chip || start_main) begin
            ctx_q.kind      <= OP_ERASE;
            ctx_q.skip_boot <= start_main || lock_boot;
            sweep_q         <= '0;
        end else begin
            if (tmr_last) ctx_q.kind <= OP_NONE;
            if (ctx_q.kind == OP_ERASE && !sweep_q[AW]) sweep_q <= sweep_q + 1'b1;
        end
    end

    fes_array #(.AW(AW)) u_array (
        .clk   (clk),
        .we    (arr_we),
        .waddr (arr_waddr),
        .wdata (arr_wdata),
        .raddr (rd_addr),
        .rdata (arr_rdata),
        .paddr (prog_addr),
        .pdata (arr_pdata)
    );

    fes_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (start_any),
        .len_m1  (start_prog ? PROG_LEN : ERASE_LEN),
        .running (tmr_running),
        .last    (tmr_last)
    );

    assign busy = tmr_running;

    fes_read_path u_read (
        .clk      (clk),
        .rst      (rst),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .busy     (busy),
        .ctx      (ctx_q),
        .arr_word (arr_rdata),
        .bus_oe   (bus_oe),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/fes_checker.sv
module fes_checker
    import fes_pkg::*;
#(
    parameter int AW         = 10,
    parameter int BOOT_WORDS = 128
) (
    input logic              clk,
    input logic              rst,
    input logic              prog_req,
    input logic [AW-1:0]     prog_addr,
    input logic              chip_erase_req,
    input logic              main_erase_req,
    input logic              lock_boot,
    input logic              ce_n,
    input logic              oe_n,
    input logic              busy,
    input logic              bus_oe,
    input logic [WORD_W-1:0] rd_data,
    input op_e               op_kind
);
    localparam logic [AW-1:0] LIM = AW'(BOOT_WORDS);

    logic plain_prog;
    assign plain_prog = !busy && prog_req && !chip_erase_req && !main_erase_req;

    AST_BUS_HIZ: assert property (@(posedge clk) disable iff (rst)
        (ce_n || oe_n) |-> (!bus_oe && rd_data == '0)); // R1

    AST_PROG_START: assert property (@(posedge clk) disable iff (rst)
        (plain_prog && !(lock_boot && prog_addr < LIM)) |=> (busy && op_kind == OP_PROG)); // R4

    AST_LOCKED_PROG: assert property (@(posedge clk) disable iff (rst)
        (plain_prog && lock_boot && prog_addr < LIM) |=> !busy); // R5

    AST_ERASE_POLL: assert property (@(posedge clk) disable iff (rst)
        (op_kind == OP_ERASE && bus_oe) |-> (rd_data[7] == 1'b0 && rd_data[15] == 1'b0)); // R9

    AST_TOGGLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && bus_oe && $past(bus_oe)) |-> $stable(rd_data[6])); // R10

    AST_TOGGLE_LANES: assert property (@(posedge clk) disable iff (rst)
        (busy && bus_oe) |-> (rd_data[6] == rd_data[14])); // R10

    AST_CHIP_PRIO: assert property (@(posedge clk) disable iff (rst)
        (!busy && chip_erase_req) |=> (busy && op_kind == OP_ERASE)); // R12
endmodule

bind flash_status_engine fes_checker #(.AW(AW), .BOOT_WORDS(BOOT_WORDS)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .prog_req       (prog_req),
    .prog_addr      (prog_addr),
    .chip_erase_req (chip_erase_req),
    .main_erase_req (main_erase_req),
    .lock_boot      (lock_boot),
    .ce_n           (ce_n),
    .oe_n           (oe_n),
    .busy           (busy),
    .bus_oe         (bus_oe),
    .rd_data        (rd_data),
    .op_kind        (op_kind)
);

// File: tb/tb_flash_status_engine.sv
`timescale 1ns/1ps
module tb_flash_status_engine;
    localparam int AW    = 10;
    localparam int BOOT  = 128;
    localparam int PCYC  = 20;
    localparam int ECYC  = 1100;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          prog_req = 1'b0;
    logic [AW-1:0] prog_addr = '0;
    logic [15:0]   prog_data = '0;
    logic          chip_erase_req = 1'b0;
    logic          main_erase_req = 1'b0;
    logic          lock_boot = 1'b0;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic [AW-1:0] rd_addr = '0;
    logic          busy;
    logic [15:0]   rd_data;
    logic          bus_oe;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    flash_status_engine #(.AW(AW), .BOOT_WORDS(BOOT), .PROG_CYCLES(PCYC), .ERASE_CYCLES(ECYC)) dut (
        .clk(clk), .rst(rst), .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
        .chip_erase_req(chip_erase_req), .main_erase_req(main_erase_req), .lock_boot(lock_boot),
        .ce_n(ce_n), .oe_n(oe_n), .rd_addr(rd_addr), .busy(busy), .rd_data(rd_data), .bus_oe(bus_oe)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // One read stretch: opens on a falling edge, spans one rising edge, closes
    task automatic read_word(input logic [AW-1:0] a, output logic [15:0] d);
        ce_n = 1'b0; oe_n = 1'b0; rd_addr = a;
        #1 d = rd_data;
        tick();
        ce_n = 1'b1; oe_n = 1'b1;
        tick();
    endtask

    task automatic request(input bit p, input bit ce, input bit me, input logic [AW-1:0] a, input logic [15:0] d);
        prog_req = p; chip_erase_req = ce; main_erase_req = me; prog_addr = a; prog_data = d;
        tick();
        prog_req = 1'b0; chip_erase_req = 1'b0; main_erase_req = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && busy; i++) tick();
    endtask

    task automatic expect_word(input logic [AW-1:0] a, input logic [15:0] exp, input string req);
        logic [15:0] d;
        read_word(a, d);
        check(d == exp, req, {16'h0, d}, {16'h0, exp});
    endtask

    task automatic t_reset();
        check(busy == 1'b0, "R13", {31'h0, busy}, 32'h0);
        check(bus_oe == 1'b0 && rd_data == 16'h0, "R13", {15'h0, bus_oe, rd_data}, 32'h0);
        ce_n = 1'b0; oe_n = 1'b1;
        #1 check(bus_oe == 1'b0 && rd_data == 16'h0, "R1", {15'h0, bus_oe, rd_data}, 32'h0);
        ce_n = 1'b1;
    endtask

    task automatic t_chip_erase_open();
        logic [15:0] r1, r2;
        lock_boot = 1'b0;
        request(1'b0, 1'b1, 1'b0, '0, '0);
        check(busy == 1'b1, "R6", {31'h0, busy}, 32'h1);
        read_word(10'd5, r1);
        read_word(10'd5, r2);
        check(r1[7] == 1'b0 && r1[15] == 1'b0, "R9", {16'h0, r1}, 32'h0);
        check(r1[6] != r2[6], "R10", {30'h0, r1[6], r2[6]}, {30'h0, r1[6], ~r1[6]});
        repeat (ECYC - 5) tick();
        check(busy == 1'b1, "R6", {31'h0, busy}, 32'h1);
        tick();
        check(busy == 1'b0, "R6", {31'h0, busy}, 32'h0);
        expect_word(10'd0,    16'hFFFF, "R6");
        expect_word(10'd127,  16'hFFFF, "R6");
        expect_word(10'd1023, 16'hFFFF, "R6");
    endtask

    task automatic t_program();
        logic [15:0] r1, r2;
        request(1'b1, 1'b0, 1'b0, 10'd200, 16'h5A3C);
        request(1'b1, 1'b0, 1'b0, 10'd201, 16'h0000); // arrives while busy
        read_word(10'd200, r1);
        read_word(10'd200, r2);
        check(r1[7] == 1'b1 && r1[15] == 1'b1, "R8", {30'h0, r1[15], r1[7]}, 32'h3);
        check((r1 & 16'h3F3F) == 16'h1A3C, "R11", {16'h0, r1 & 16'h3F3F}, 32'h1A3C);
        check(r1[6] == r1[14] && r1[6] != r2[6], "R10", {28'h0, r1[14], r1[6], r2[14], r2[6]}, {28'h0, r1[6], r1[6], ~r1[6], ~r1[6]});
        wait_idle();
        read_word(10'd200, r1);
        read_word(10'd200, r2);
        check(r1 == 16'h5A3C, "R3", {16'h0, r1}, 32'h5A3C);
        check(r2 == r1, "R10", {16'h0, r2}, {16'h0, r1});
        expect_word(10'd201, 16'hFFFF, "R12");
        request(1'b1, 1'b0, 1'b0, 10'd200, 16'hFF0F);
        wait_idle();
        expect_word(10'd200, 16'h5A0C, "R3");
    endtask

    task automatic t_prog_duration();
        request(1'b1, 1'b0, 1'b0, 10'd210, 16'hFFFF);
        check(busy == 1'b1, "R4", {31'h0, busy}, 32'h1);
        repeat (PCYC - 1) tick();
        check(busy == 1'b1, "R4", {31'h0, busy}, 32'h1);
        tick();
        check(busy == 1'b0, "R4", {31'h0, busy}, 32'h0);
    endtask

    task automatic t_lockout();
        lock_boot = 1'b0;
        request(1'b1, 1'b0, 1'b0, 10'd50, 16'h1234);
        wait_idle();
        expect_word(10'd50, 16'h1234, "R2");
        lock_boot = 1'b1;
        request(1'b1, 1'b0, 1'b0, 10'd50, 16'h0000);
        check(busy == 1'b0, "R5", {31'h0, busy}, 32'h0);
        expect_word(10'd50, 16'h1234, "R5");
        request(1'b1, 1'b0, 1'b0, 10'd500, 16'h00FF);
        wait_idle();
        expect_word(10'd500, 16'h00FF, "R5");
        request(1'b0, 1'b1, 1'b0, '0, '0);
        wait_idle();
        expect_word(10'd50,  16'h1234, "R6");
        expect_word(10'd500, 16'hFFFF, "R6");
        expect_word(10'd200, 16'hFFFF, "R6");
        lock_boot = 1'b0;
    endtask

    task automatic t_main_erase();
        request(1'b1, 1'b0, 1'b0, 10'd60, 16'h0F0F);
        wait_idle();
        request(1'b1, 1'b0, 1'b0, 10'd300, 16'h0000);
        wait_idle();
        request(1'b0, 1'b0, 1'b1, '0, '0);
        wait_idle();
        expect_word(10'd60,  16'h0F0F, "R7");
        expect_word(10'd50,  16'h1234, "R7");
        expect_word(10'd300, 16'hFFFF, "R7");
    endtask

    task automatic t_priority();
        request(1'b1, 1'b0, 1'b0, 10'd400, 16'h0000);
        wait_idle();
        request(1'b1, 1'b0, 1'b1, 10'd400, 16'h0000); // main erase beats program
        repeat (PCYC + 5) tick();
        check(busy == 1'b1, "R12", {31'h0, busy}, 32'h1);
        wait_idle();
        expect_word(10'd400, 16'hFFFF, "R12");
        request(1'b0, 1'b1, 1'b1, '0, '0); // chip erase beats main erase
        wait_idle();
        expect_word(10'd60, 16'hFFFF, "R12");
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        tick();
        t_chip_erase_open();
        t_program();
        t_prog_duration();
        t_lockout();
        t_main_erase();
        t_priority();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule